// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle I/O Register Pair

This block holds two 32-bit control registers, an output-data register and an output-enable register, that software can change bit by bit without a read-modify-write. Each register is reached through a group of four consecutive 32-bit words. One word reads and writes the whole value. The other three take masks: one sets the marked bits, one clears them, and one inverts them. A third word returns the input pins after a synchronizer. Used together, the two registers and the pin word form a general-purpose I/O port. The external tristate buffers are outside the block.

The software bus carries `LANES` 32-bit lanes per beat and has a strobe for each lane. Word index = beat * LANES + lane. With the default two lanes, a single 64-bit beat can carry the set mask and the clear mask together, and both are applied in the same cycle. The fabric can also load either register with a complete new value through a strobe-qualified input. This load has priority over software. Reads are registered and return one cycle after the request.

Top module: `atomic_gpio_regs`

## Requirements
- R1: After a synchronous active-high reset, `pin_out`, `pin_oe` and `rd_data` are all zero and `rd_valid` is low.
- R2: Inside a group the word offsets are: +0 value, +1 toggle, +2 set, +3 clear. A write to the value word loads the full lane data into the register.
- R3: A write to the set word makes every bit that is 1 in the mask equal to 1 and leaves the other bits unchanged.
- R4: A write to the clear word makes every bit that is 1 in the mask equal to 0 and leaves the other bits unchanged.
- R5: A write to the toggle word inverts every bit that is 1 in the mask.
- R6: A beat that writes the set word (lane 0) and the clear word (lane 1) together gives (value & ~clear) | set. Where the two masks overlap, set wins.
- R7: A beat that writes the value word (lane 0) and the toggle word (lane 1) together loads the written value with the toggle mask applied.
- R8: When a fabric strobe is high, the register takes the fabric value on the next edge. This holds even if a software write to the same group happens in the same cycle.
- R9: The output-data group is at words 0-3 and the output-enable group is at words 4-7. A write to one group leaves the other register unchanged. A register with no write and no strobe holds its value.
- R10: `rd_valid` goes high exactly one cycle after `rd_en`. `rd_data` then holds the value word of each group, and zero for the set, clear and toggle words.
- R11: Word 8 reads back `pin_in` after a `SYNC_STAGES`-flop synchronizer.
- R12: A read of an unmapped word returns zero. A write to an unmapped word, or a write to a lane whose strobe is low, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write request |
| wr_beat | input | BADDR_W | Beat address of the write |
| wr_strb | input | LANES | Per-lane write enables |
| wr_data | input | LANES*DATA_W | Write data, lane 0 in the low bits |
| rd_en | input | 1 | Software read request |
| rd_beat | input | BADDR_W | Beat address of the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | LANES*DATA_W | Registered read data |
| fab_out_we | input | 1 | Fabric strobe for the output-data register |
| fab_out_d | input | DATA_W | Fabric value for the output-data register |
| fab_oe_we | input | 1 | Fabric strobe for the output-enable register |
| fab_oe_d | input | DATA_W | Fabric value for the output-enable register |
| pin_in | input | DATA_W | Input pin levels |
| pin_out | output | DATA_W | Output-data register |
| pin_oe | output | DATA_W | Output-enable register |

## Verification
The bench uses the default parameters: DATA_W=32, LANES=2, BADDR_W=3, SYNC_STAGES=2. Two lanes let it drive the dual-word beats that matter here: set plus clear in one beat with overlapping masks, and value plus toggle in one beat. Three beat-address bits reach words 9 to 15, so the unmapped-word cases are covered. It also drives fabric strobes that collide with software mask writes, and it reads the pin word after the synchronizer has settled.

// File: rtl/atomreg_pkg.sv
package atomreg_pkg;
  // Word offset inside a four-word register group. Set sits at an even
  // offset and clear just above it, so one two-lane beat carries both.
  typedef enum logic [1:0] {
    AK_VALUE  = 2'd0,
    AK_TOGGLE = 2'd1,
    AK_SET    = 2'd2,
    AK_CLEAR  = 2'd3
  } atom_kind_e;

  localparam int GROUP_WORDS = 4;
  localparam int GROUP_SHIFT = 2;
endpackage

// File: rtl/atom_wr_decode.sv
module atom_wr_decode
  import atomreg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LANES   = 2,
  parameter int BADDR_W = 3,
  parameter int NGRP    = 2
) (
  input  logic                           wr_en,
  input  logic [BADDR_W-1:0]             wr_beat,
  input  logic [LANES-1:0]               wr_strb,
  input  logic [LANES*DATA_W-1:0]        wr_data,
  output logic [NGRP-1:0]                val_we,
  output logic [NGRP-1:0][DATA_W-1:0]    val_d,
  output logic [NGRP-1:0][DATA_W-1:0]    set_m,
  output logic [NGRP-1:0][DATA_W-1:0]    clr_m,
  output logic [NGRP-1:0][DATA_W-1:0]    tgl_m
);
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WIDX_W    = BADDR_W + LANE_BITS + 1;

  logic [LANES-1:0][WIDX_W-1:0] lane_word;

  // Word index carried by each lane of this beat
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane_idx
      assign lane_word[l] = WIDX_W'(wr_beat) * WIDX_W'(LANES) + WIDX_W'(l);
    end
  endgenerate

  always_comb begin
    val_we = '0;
    val_d  = '0;
    set_m  = '0;
    clr_m  = '0;
    tgl_m  = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en && wr_strb[l] &&
            (lane_word[l][WIDX_W-1:GROUP_SHIFT] == (WIDX_W-GROUP_SHIFT)'(g))) begin
          case (atom_kind_e'(lane_word[l][GROUP_SHIFT-1:0]))
            AK_VALUE: begin
              val_we[g] = 1'b1;
              val_d[g]  = val_d[g] | wr_data[l*DATA_W +: DATA_W];
            end
            AK_TOGGLE: tgl_m[g] = tgl_m[g] | wr_data[l*DATA_W +: DATA_W];
            AK_SET:    set_m[g] = set_m[g] | wr_data[l*DATA_W +: DATA_W];
            default:   clr_m[g] = clr_m[g] | wr_data[l*DATA_W +: DATA_W];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/atom_bit_reg.sv
module atom_bit_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              val_we,
  input  logic [DATA_W-1:0] val_d,
  input  logic [DATA_W-1:0] set_m,
  input  logic [DATA_W-1:0] clr_m,
  input  logic [DATA_W-1:0] tgl_m,
  input  logic              fab_we,
  input  logic [DATA_W-1:0] fab_d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    base = val_we ? val_d : q_r;
    nxt  = ((base & ~clr_m) | set_m) ^ tgl_m;
    if (fab_we) nxt = fab_d;
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/atom_pin_sync.sv
module atom_pin_sync #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [SYNC_STAGES-1:0][DATA_W-1:0] chain;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[SYNC_STAGES-1];
endmodule

// File: rtl/atom_rd_mux.sv
module atom_rd_mux
  import atomreg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LANES   = 2,
  parameter int BADDR_W = 3,
  parameter int NGRP    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [BADDR_W-1:0]          rd_beat,
  input  logic [NGRP-1:0][DATA_W-1:0] grp_val,
  input  logic [DATA_W-1:0]           pins,
  output logic                        rd_valid,
  output logic [LANES*DATA_W-1:0]     rd_data
);
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WIDX_W    = BADDR_W + LANE_BITS + 1;
  localparam int PIN_WORD  = NGRP * GROUP_WORDS;

  logic [LANES*DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [WIDX_W-1:0] w;
      w = WIDX_W'(rd_beat) * WIDX_W'(LANES) + WIDX_W'(l);
      if (w == WIDX_W'(PIN_WORD)) begin
        sel[l*DATA_W +: DATA_W] = pins;
      end else begin
        for (int g = 0; g < NGRP; g++) begin
          if (w[WIDX_W-1:GROUP_SHIFT] == (WIDX_W-GROUP_SHIFT)'(g) &&
              atom_kind_e'(w[GROUP_SHIFT-1:0]) == AK_VALUE)
            sel[l*DATA_W +: DATA_W] = grp_val[g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/atomic_gpio_regs.sv
module atomic_gpio_regs #(
  parameter int DATA_W      = 32,
  parameter int LANES       = 2,
  parameter int BADDR_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [BADDR_W-1:0]        wr_beat,
  input  logic [LANES-1:0]          wr_strb,
  input  logic [LANES*DATA_W-1:0]   wr_data,
  input  logic                      rd_en,
  input  logic [BADDR_W-1:0]        rd_beat,
  output logic                      rd_valid,
  output logic [LANES*DATA_W-1:0]   rd_data,
  input  logic                      fab_out_we,
  input  logic [DATA_W-1:0]         fab_out_d,
  input  logic                      fab_oe_we,
  input  logic [DATA_W-1:0]         fab_oe_d,
  input  logic [DATA_W-1:0]         pin_in,
  output logic [DATA_W-1:0]         pin_out,
  output logic [DATA_W-1:0]         pin_oe
);
  // Group 0 drives the output data, group 1 the output enables
  localparam int NGRP = 2;

  logic [NGRP-1:0]              val_we;
  logic [NGRP-1:0][DATA_W-1:0]  val_d, set_m, clr_m, tgl_m;
  logic [NGRP-1:0]              fab_we;
  logic [NGRP-1:0][DATA_W-1:0]  fab_d;
  logic [NGRP-1:0][DATA_W-1:0]  grp_q;
  logic [DATA_W-1:0]            pins_s;

  assign fab_we = {fab_oe_we, fab_out_we};
  assign fab_d  = {fab_oe_d, fab_out_d};

  atom_wr_decode #(
    .DATA_W(DATA_W), .LANES(LANES), .BADDR_W(BADDR_W), .NGRP(NGRP)
  ) u_dec (
    .wr_en(wr_en), .wr_beat(wr_beat), .wr_strb(wr_strb), .wr_data(wr_data),
    .val_we(val_we), .val_d(val_d), .set_m(set_m), .clr_m(clr_m), .tgl_m(tgl_m)
  );

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_reg
      atom_bit_reg #(.DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst(rst),
        .val_we(val_we[g]), .val_d(val_d[g]),
        .set_m(set_m[g]), .clr_m(clr_m[g]), .tgl_m(tgl_m[g]),
        .fab_we(fab_we[g]), .fab_d(fab_d[g]),
        .q(grp_q[g])
      );
    end
  endgenerate

  atom_pin_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
  );

  atom_rd_mux #(
    .DATA_W(DATA_W), .LANES(LANES), .BADDR_W(BADDR_W), .NGRP(NGRP)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_beat(rd_beat),
    .grp_val(grp_q), .pins(pins_s),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign pin_out = grp_q[0];
  assign pin_oe  = grp_q[1];
endmodule

// File: rtl/atomic_gpio_regs_chk.sv
module atomic_gpio_regs_chk #(
  parameter int DATA_W  = 32,
  parameter int LANES   = 2,
  parameter int BADDR_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [BADDR_W-1:0]      wr_beat,
  input logic [LANES-1:0]        wr_strb,
  input logic [LANES*DATA_W-1:0] wr_data,
  input logic                    rd_en,
  input logic                    rd_valid,
  input logic                    fab_out_we,
  input logic [DATA_W-1:0]       fab_out_d,
  input logic [DATA_W-1:0]       pin_out,
  input logic [DATA_W-1:0]       pin_oe
);
  // Classify the current write as seen on the bus, for group 0 only
  logic              touch0;
  logic              set_seen;
  logic              other0;
  logic [DATA_W-1:0] set_mask;

  always_comb begin
    touch0   = 1'b0;
    set_seen = 1'b0;
    other0   = 1'b0;
    set_mask = '0;
    for (int l = 0; l < LANES; l++) begin
      int w;
      w = int'(wr_beat) * LANES + l;
      if (wr_en && wr_strb[l] && w < 4) begin
        touch0 = 1'b1;
        if (w == 2) begin
          set_seen = 1'b1;
          set_mask = wr_data[l*DATA_W +: DATA_W];
        end else begin
          other0 = 1'b1;
        end
      end
    end
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> (pin_out == '0 && pin_oe == '0 && !rd_valid));

  // R8
  fab_prio_chk: assert property (@(posedge clk) disable iff (rst)
    fab_out_we |=> pin_out == $past(fab_out_d));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fab_out_we && !touch0) |=> $stable(pin_out));

  // R3
  set_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (set_seen && !other0 && !fab_out_we) |=> pin_out == ($past(pin_out) | $past(set_mask)));

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind atomic_gpio_regs atomic_gpio_regs_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .BADDR_W(BADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_beat(wr_beat), .wr_strb(wr_strb),
  .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
  .fab_out_we(fab_out_we), .fab_out_d(fab_out_d),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/atomic_gpio_regs_tb_top.sv
module atomic_gpio_regs_tb_top;
  localparam int DATA_W = 32;
  localparam int LANES  = 2;
  localparam int BADDR_W = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_beat;
  logic [1:0]  wr_strb;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [2:0]  rd_beat;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        fab_out_we, fab_oe_we;
  logic [31:0] fab_out_d, fab_oe_d, pin_in, pin_out, pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_out = '0;
  logic [31:0] exp_oe  = '0;

  always #5 clk = ~clk;

  atomic_gpio_regs #(.DATA_W(DATA_W), .LANES(LANES), .BADDR_W(BADDR_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_beat(wr_beat), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_en(rd_en), .rd_beat(rd_beat), .rd_valid(rd_valid),
    .rd_data(rd_data), .fab_out_we(fab_out_we), .fab_out_d(fab_out_d),
    .fab_oe_we(fab_oe_we), .fab_oe_d(fab_oe_d), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One software write beat; outputs settle by the following falling edge
  task automatic sw_write(input logic [2:0] beat, input logic [1:0] strb, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_beat = beat; wr_strb = strb; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  task automatic sw_read(input logic [2:0] beat, output logic [63:0] data, output logic vld);
    @(negedge clk);
    rd_en = 1'b1; rd_beat = beat;
    @(negedge clk);
    rd_en = 1'b0;
    data = rd_data; vld = rd_valid;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic v;
    check("R1 pin_out", {32'b0, pin_out}, 64'h0);
    check("R1 pin_oe", {32'b0, pin_oe}, 64'h0);
    check("R1 rd_valid", {63'b0, rd_valid}, 64'h0);
    check("R1 rd_data", rd_data, 64'h0);
    sw_read(3'd0, d, v);
    check("R1 value word after reset", d, 64'h0);
  endtask

  task automatic t_single_masks;
    sw_write(3'd0, 2'b01, 64'h0000_0000_A5A5_0F0F);
    exp_out = 32'hA5A5_0F0F;
    check("R2 value write", {32'b0, pin_out}, {32'b0, exp_out});
    sw_write(3'd1, 2'b01, 64'h0000_0000_0000_F000);
    exp_out = 32'hA5A5_FF0F;
    check("R3 set mask", {32'b0, pin_out}, {32'b0, exp_out});
    sw_write(3'd1, 2'b10, 64'h00A0_0000_0000_0000);
    exp_out = 32'hA505_FF0F;
    check("R4 clear mask", {32'b0, pin_out}, {32'b0, exp_out});
    sw_write(3'd0, 2'b10, 64'hFFFF_0000_0000_0000);
    exp_out = 32'h5AFA_FF0F;
    check("R5 toggle mask", {32'b0, pin_out}, {32'b0, exp_out});
  endtask

  task automatic t_dual_beats;
    // set=0x0000_00F0 in lane 0, clear=0x0000_00FF in lane 1
    sw_write(3'd1, 2'b11, 64'h0000_00FF_0000_00F0);
    exp_out = (exp_out & ~32'h0000_00FF) | 32'h0000_00F0;
    check("R6 set+clear same beat", {32'b0, pin_out}, {32'b0, exp_out});
    sw_write(3'd0, 2'b11, 64'h0000_00FF_1234_5678);
    exp_out = 32'h1234_5687;
    check("R7 value+toggle same beat", {32'b0, pin_out}, {32'b0, exp_out});
  endtask

  task automatic t_fabric;
    @(negedge clk);
    fab_out_we = 1'b1; fab_out_d = 32'hCAFE_0001;
    @(negedge clk);
    fab_out_we = 1'b0;
    exp_out = 32'hCAFE_0001;
    check("R8 fabric load", {32'b0, pin_out}, {32'b0, exp_out});
    @(negedge clk);
    fab_out_we = 1'b1; fab_out_d = 32'h0000_1111;
    wr_en = 1'b1; wr_beat = 3'd1; wr_strb = 2'b01; wr_data = 64'h0000_0000_FFFF_0000;
    @(negedge clk);
    fab_out_we = 1'b0; wr_en = 1'b0; wr_strb = '0;
    exp_out = 32'h0000_1111;
    check("R8 fabric beats set write", {32'b0, pin_out}, {32'b0, exp_out});
  endtask

  task automatic t_groups_and_reads;
    logic [63:0] d; logic v;
    sw_write(3'd3, 2'b01, 64'h0000_0000_0000_00F3);
    exp_oe = 32'h0000_00F3;
    check("R9 oe set", {32'b0, pin_oe}, {32'b0, exp_oe});
    check("R9 out untouched by oe write", {32'b0, pin_out}, {32'b0, exp_out});
    fab_oe_we = 1'b0;
    sw_read(3'd0, d, v);
    check("R10 rd_valid", {63'b0, v}, 64'h1);
    check("R10 value word and toggle word zero", d, {32'b0, exp_out});
    sw_read(3'd1, d, v);
    check("R10 set and clear words zero", d, 64'h0);
    sw_read(3'd2, d, v);
    check("R10 oe value word", d, {32'b0, exp_oe});
    @(negedge clk);
    check("R10 rd_valid drops", {63'b0, rd_valid}, 64'h0);
  endtask

  task automatic t_pins_unmapped;
    logic [63:0] d; logic v;
    @(negedge clk);
    pin_in = 32'h8001_7E00;
    repeat (4) @(negedge clk);
    sw_read(3'd4, d, v);
    check("R11 pin word, word 9 zero", d, 64'h0000_0000_8001_7E00);
    sw_read(3'd6, d, v);
    check("R12 unmapped read", d, 64'h0);
    sw_write(3'd5, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    sw_write(3'd4, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R12 unmapped write out", {32'b0, pin_out}, {32'b0, exp_out});
    check("R12 unmapped write oe", {32'b0, pin_oe}, {32'b0, exp_oe});
    sw_write(3'd0, 2'b00, 64'h0000_0000_DEAD_BEEF);
    check("R12 strobe-low lane ignored", {32'b0, pin_out}, {32'b0, exp_out});
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_beat = '0; wr_strb = '0; wr_data = '0;
    rd_en = 1'b0; rd_beat = '0; fab_out_we = 1'b0; fab_oe_we = 1'b0;
    fab_out_d = '0; fab_oe_d = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single_masks();
    t_dual_beats();
    t_fabric();
    t_groups_and_reads();
    t_pins_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule